// File: doc/BRIEF.md
# DMA Completion Interrupt Coalescing Timer

This block sits between a DMA channel's completion logic and its interrupt line. It cuts down the number of interrupts the host has to service. Each finished operation presents a completion pulse with an interrupt-request bit. Software normally sets that bit only on the last operation of a batch. A programmable delay, in microseconds, controls how requests are merged. With a delay of zero, every requesting completion raises the interrupt line on the next clock edge. With a nonzero delay, the first requesting completion starts a countdown driven by an external one-microsecond tick. Later requests are folded into that countdown, and one interrupt is raised when it runs out.

The interrupt line stays high until the host acknowledges it. Requests that arrive while it is still pending are merged into that interrupt. The delay is set through a simple write port. A value above the hardware ceiling is refused with a range-error pulse, and the old setting is kept. A constant output reports the ceiling, or zero in a build without coalescing.

Top module: `irq_coalesce_top`

## Requirements
- R1: After reset, `irq` is 0, `cfg_err` is 0 and `cfg_delay` is 0 (coalescing off).
- R2: `max_delay` reports 0x3FFF when coalescing is built in (COAL_EN=1) and 0 otherwise.
- R3: A write with `cfg_data` at or below `max_delay` makes `cfg_delay` equal to that value from the next clock edge, with `cfg_err` low.
- R4: A write with `cfg_data` above `max_delay` leaves `cfg_delay` unchanged and raises `cfg_err` for exactly one cycle after the write edge.
- R5: With `cfg_delay` equal to 0, a cycle with `done_vld`=1 and `done_irq_en`=1 raises `irq` at that same clock edge.
- R6: A completion with `done_irq_en`=0 never raises `irq` and never starts the countdown.
- R7: With `cfg_delay` = N > 0 and no interrupt pending, a requesting completion starts a countdown. `irq` rises on the edge that samples the N-th `us_tick` after the starting edge, and not earlier.
- R8: Requesting completions during a running countdown do not restart it, and the countdown produces exactly one interrupt.
- R9: `irq` stays high until a cycle with `irq_ack`=1 clears it. Requesting completions while it is pending and not being acknowledged are absorbed and start no new countdown.
- R10: A requesting completion in the same cycle as `irq_ack` counts as a new request. With delay 0, `irq` stays high. With delay N, a fresh countdown starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Delay write strobe |
| cfg_data | input | 16 | Requested delay in microseconds |
| cfg_err | output | 1 | One-cycle range-error pulse after a refused write |
| cfg_delay | output | 14 | Delay currently in force |
| max_delay | output | 14 | Largest accepted delay, 0 when coalescing is absent |
| done_vld | input | 1 | Operation completion pulse |
| done_irq_en | input | 1 | Completion asks for an interrupt |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| irq | output | 1 | Pending interrupt, level |
| irq_ack | input | 1 | Interrupt acknowledge |

## Verification
A table of delay writes drives values in range, exactly at the ceiling, one above it and far above it, and zero. This separates an off-by-one in the limit compare from a dropped error pulse, and a refused write that corrupts the setting from one that leaves it intact. Completion patterns are then tried in four forms: with and without the request bit, single and repeated within one countdown, before and after acknowledge, and coinciding with acknowledge. These separate a countdown that restarts from one that runs to the end. They also show whether the tick count is off by one, whether pending requests are merged, and whether a request arriving with the acknowledge is lost.

// File: rtl/coal_pkg.sv
package coal_pkg;
   typedef enum logic {TMR_IDLE = 1'b0, TMR_RUN = 1'b1} tmr_state_t;
endpackage

// File: rtl/coal_cfg.sv
module coal_cfg #(
   parameter int DELAY_W = 14,
   parameter int CFG_W   = 16,
   parameter bit COAL_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_i,
   input  logic [CFG_W-1:0]   data_i,
   output logic [DELAY_W-1:0] delay_o,
   output logic [DELAY_W-1:0] max_o,
   output logic               err_o
);
   localparam logic [DELAY_W-1:0] CEIL = DELAY_W'((1 << DELAY_W) - 1);

   logic [DELAY_W-1:0] limit;
   logic [CFG_W-1:0]   limit_ext;
   logic               too_big;

   generate
      if (COAL_EN) begin : g_coal
         assign limit = CEIL;
      end else begin : g_nocoal
         assign limit = '0;
      end
   endgenerate

   assign limit_ext = CFG_W'(limit);
   assign too_big   = data_i > limit_ext;
   assign max_o     = limit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         delay_o <= '0;
         err_o   <= 1'b0;
      end else if (wr_i) begin
         err_o <= too_big;
         if (!too_big) delay_o <= data_i[DELAY_W-1:0];
      end else begin
         err_o <= 1'b0;
      end
   end

   assert_delay_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      delay_o <= limit);
   assert_refused_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && too_big) |=> $stable(delay_o));
   assert_err_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_o) |-> $past(wr_i && too_big));
endmodule

// File: rtl/coal_timer.sv
module coal_timer
   import coal_pkg::*;
#(
   parameter int DELAY_W = 14
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [DELAY_W-1:0] load_i,
   input  logic               tick_i,
   output logic               busy_o,
   output logic               expire_o
);
   localparam logic [DELAY_W-1:0] ONE = DELAY_W'(1);

   tmr_state_t         state;
   logic [DELAY_W-1:0] cnt;

   assign busy_o   = (state == TMR_RUN);
   assign expire_o = busy_o && tick_i && (cnt == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= TMR_IDLE;
         cnt   <= '0;
      end else if (!busy_o) begin
         if (start_i) begin
            state <= TMR_RUN;
            cnt   <= load_i;
         end
      end else if (expire_o) begin
         state <= TMR_IDLE;
         cnt   <= '0;
      end else if (tick_i) begin
         cnt <= cnt - ONE;
      end
   end

   assert_run_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (cnt != '0));
   assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !tick_i) |=> $stable(cnt));
endmodule

// File: rtl/coal_flag.sv
module coal_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic irq_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     irq_o <= 1'b0;
      else if (set_i) irq_o <= 1'b1;
      else if (clr_i) irq_o <= 1'b0;
   end

   assert_hold_until_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !clr_i) |=> irq_o);
endmodule

// File: rtl/irq_coalesce_top.sv
module irq_coalesce_top #(
   parameter int DELAY_W = 14,
   parameter int CFG_W   = 16,
   parameter bit COAL_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_wr,
   input  logic [CFG_W-1:0]   cfg_data,
   output logic               cfg_err,
   output logic [DELAY_W-1:0] cfg_delay,
   output logic [DELAY_W-1:0] max_delay,
   input  logic               done_vld,
   input  logic               done_irq_en,
   input  logic               us_tick,
   output logic               irq,
   input  logic               irq_ack
);
   generate
      if (CFG_W < DELAY_W) begin : g_bad_cfg_w
         $error("CFG_W must be at least DELAY_W");
      end
      if (DELAY_W < 1 || DELAY_W > 30) begin : g_bad_delay_w
         $error("DELAY_W out of range");
      end
   endgenerate

   logic req, bypass, pend_live, busy, expire, start, set_irq;

   coal_cfg #(.DELAY_W(DELAY_W), .CFG_W(CFG_W), .COAL_EN(COAL_EN)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_i(cfg_wr), .data_i(cfg_data),
      .delay_o(cfg_delay), .max_o(max_delay), .err_o(cfg_err));

   assign req       = done_vld && done_irq_en;
   assign bypass    = (cfg_delay == '0);
   assign pend_live = irq && !irq_ack;
   assign start     = req && !bypass && !pend_live && !busy;
   assign set_irq   = expire || (req && bypass);

   coal_timer #(.DELAY_W(DELAY_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .start_i(start), .load_i(cfg_delay),
      .tick_i(us_tick), .busy_o(busy), .expire_o(expire));

   coal_flag u_flag (
      .clk(clk), .rst_n(rst_n), .set_i(set_irq), .clr_i(irq_ack), .irq_o(irq));

   assert_bypass_immediate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req && bypass) |=> irq);
   assert_rise_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(expire || (req && bypass)));
   assert_ack_with_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && req && !bypass && !busy) |=> busy);
endmodule

// File: tb/test_irq_coalesce_top.sv
module test_irq_coalesce_top;
   localparam int NV = 6;
   localparam logic [15:0] V_DATA [NV] = '{16'h0005, 16'h3FFF, 16'h4000, 16'hFFFF, 16'h0000, 16'h0003};
   localparam logic        V_ERR  [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0};
   localparam logic [13:0] V_DLY  [NV] = '{14'h0005, 14'h3FFF, 14'h3FFF, 14'h3FFF, 14'h0000, 14'h0003};

   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_wr = 1'b0, done_vld = 1'b0, done_irq_en = 1'b0, us_tick = 1'b0, irq_ack = 1'b0;
   logic [15:0] cfg_data = '0;
   logic cfg_err, irq;
   logic [13:0] cfg_delay, max_delay;
   int n_total = 0, n_fail = 0;
   bit done_flag = 1'b0;

   always #2 clk = ~clk;

   irq_coalesce_top i_irq_coalesce_top (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data), .cfg_err(cfg_err),
      .cfg_delay(cfg_delay), .max_delay(max_delay), .done_vld(done_vld),
      .done_irq_en(done_irq_en), .us_tick(us_tick), .irq(irq), .irq_ack(irq_ack));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_total++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic cyc(input logic d, input logic e, input logic t, input logic a);
      done_vld = d; done_irq_en = e; us_tick = t; irq_ack = a;
      @(posedge clk); @(negedge clk);
      done_vld = 0; done_irq_en = 0; us_tick = 0; irq_ack = 0;
   endtask

   task automatic wr(input logic [15:0] v);
      cfg_wr = 1; cfg_data = v;
      @(posedge clk); @(negedge clk);
      cfg_wr = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 irq", irq, 0);
      check("R1 cfg_err", cfg_err, 0);
      check("R1 cfg_delay", cfg_delay, 0);
      rst_n = 1;
      @(negedge clk);
      check("R2 max_delay", max_delay, 14'h3FFF);

      // R3 / R4: configuration table
      for (int i = 0; i < NV; i++) begin
         wr(V_DATA[i]);
         check(V_ERR[i] ? "R4 err" : "R3 err", cfg_err, V_ERR[i]);
         check(V_ERR[i] ? "R4 delay kept" : "R3 delay", cfg_delay, V_DLY[i]);
         cyc(0, 0, 0, 0);
         check("R4 err one cycle", cfg_err, 0);
      end

      // R7: delay 3, irq on third tick
      cyc(1, 1, 0, 0);
      check("R7 no irq at start", irq, 0);
      cyc(0, 0, 1, 0);
      cyc(0, 0, 0, 0);
      cyc(0, 0, 1, 0);
      check("R7 no irq after 2 ticks", irq, 0);
      cyc(0, 0, 1, 0);
      check("R7 irq after 3 ticks", irq, 1);
      cyc(0, 0, 0, 0);
      check("R9 irq held", irq, 1);
      cyc(0, 0, 0, 1);
      check("R9 ack clears", irq, 0);

      // R8: extra requests do not restart
      cyc(1, 1, 0, 0);
      cyc(0, 0, 1, 0);
      cyc(1, 1, 0, 0);
      cyc(0, 0, 1, 0);
      cyc(1, 1, 1, 0);
      check("R8 expires on first countdown", irq, 1);
      cyc(0, 0, 0, 1);
      repeat (5) cyc(0, 0, 1, 0);
      check("R8 single interrupt", irq, 0);

      // R9: requests while pending absorbed
      cyc(1, 1, 0, 0);
      repeat (3) cyc(0, 0, 1, 0);
      check("R9 pending", irq, 1);
      cyc(1, 1, 0, 0);
      cyc(0, 0, 0, 1);
      repeat (4) cyc(0, 0, 1, 0);
      check("R9 merged request no new irq", irq, 0);

      // R6: request bit clear
      cyc(1, 0, 0, 0);
      repeat (4) cyc(0, 0, 1, 0);
      check("R6 no irq with delay 3", irq, 0);

      // R10: request with ack, delay 3
      cyc(1, 1, 0, 0);
      repeat (3) cyc(0, 0, 1, 0);
      cyc(1, 1, 0, 1);
      check("R10 ack clears", irq, 0);
      cyc(0, 0, 1, 0);
      cyc(0, 0, 1, 0);
      check("R10 not yet", irq, 0);
      cyc(0, 0, 1, 0);
      check("R10 new countdown", irq, 1);
      cyc(0, 0, 0, 1);

      // R5: bypass
      wr(16'h0000);
      cyc(1, 0, 0, 0);
      check("R6 no irq with delay 0", irq, 0);
      cyc(1, 1, 0, 0);
      check("R5 immediate irq", irq, 1);
      cyc(1, 1, 0, 1);
      check("R10 bypass request with ack", irq, 1);
      cyc(0, 0, 0, 1);
      check("R9 ack bypass", irq, 0);

      done_flag = 1;
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end

   initial begin
      #800000;
      if (!done_flag) begin
         n_total++; n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("%0d/%0d checks passed", n_total - n_fail, n_total);
         $finish;
      end
   end
endmodule